// File: doc/BRIEF.md
# Eighteen-Point DCT-IV Core

This block evaluates the 18-point type-IV discrete cosine transform that sits at the heart of the long-block MDCT/IMDCT in a perceptual audio codec: X(k) = sum over i of x(i)·cos(π(2i+1)(2k+1)/72). It takes a whole block of 18 signed samples in one cycle and returns all 18 coefficients two clock edges later, accepting a new block every cycle.

The outputs are split by number theory. An output whose odd index 2k+1 is a multiple of 3 comes from a 6-point DCT-IV of a folded input, y(i) = x(i) − x(11−i) − x(12+i). Every other output (2k+1 coprime to 144) comes from a cosine group transform. That transform is the sum of two parts. One is a reduced 6-input sub-transform of the samples whose 2i+1 is a multiple of 3; it only needs four distinct row sums, because of sign symmetries. The other is a 12×12 product over the remaining samples. All constant products are formed in one multiplier stage, registered, and then summed, so each path holds only one multiplication.

A per-block mode input lets the shared 6-point section run a standalone short block. In that mode the other two sections get zero operands, so they do not toggle.

Top module: `dct18_core`

## Requirements
- R1: In long mode (`in_mode`=0), each lane k with 2k+1 a multiple of 3 (k = 1,4,7,10,13,16) equals Σ x(i)cos(π(2i+1)(2k+1)/72) to within 2 + Σ|x(i)|/2^(FB+1) LSB. The output has the same integer scale as the input.
- R2: In long mode, each of the other twelve lanes (2k+1 coprime to 144) equals the same 18-point sum within the same tolerance.
- R3: In short mode (`in_mode`=1), lanes 0..5 equal Σ over i<6 of x(i)cos(π(2i+1)(2k+1)/24) within 2 + Σ|x(i)|/2^(FB+1), and input lanes 6..17 have no effect on any output.
- R4: In short mode, output lanes 6..17 are exactly zero.
- R5: `out_valid` is high exactly two rising clock edges after `in_valid` was sampled high. A new block may be supplied on every cycle.
- R6: When no block completes, `x_out` holds its previous value, whatever `x_in` and `in_mode` do.
- R7: While `rst_n` is low, `out_valid` is 0 and every output lane is 0; a reset during a block discards it.
- R8: The mode is captured with each block, so back-to-back blocks of different modes each give their own correct result.
- R9: Full-scale inputs, including the most negative code on every lane, stay within the R1–R3 tolerance without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A block is presented on `x_in` this cycle |
| in_mode | input | 1 | 0 = 18-point long block, 1 = 6-point short block on lanes 0..5 |
| x_in | input | 18·DW | Input samples, lane i at bits [i·DW +: DW], two's complement |
| out_valid | output | 1 | `x_out` carries a new block this cycle |
| x_out | output | 18·(DW+5) | Coefficients, lane k at bits [k·(DW+5) +: DW+5], two's complement |

## Verification
The assertions take two things for granted. First, `in_valid` and `in_mode` are held at zero for at least two cycles before reset is released, so the two-cycle history the latency property looks at never reaches back into an interrupted block. Second, the mode only matters on cycles where a block is accepted. The stimulus meets both conditions: it drives all inputs on the falling edge, and it keeps `in_valid` low throughout every reset. Between blocks it changes `x_in` and `in_mode` freely to probe the hold behaviour, and in short mode it fills input lanes 6..17 with nonzero values to show that they are ignored.

// File: rtl/dct18_pkg.sv
package dct18_pkg;

   localparam int NPT   = 18;   // long-block transform length
   localparam int NSUB  = 6;    // short / folded sub-transform length
   localparam int NUNIT = 12;   // lanes whose odd index is coprime to 144
   localparam int NHALF = 4;    // distinct row sums of the reduced sub-transform

   localparam int KIND_DCT6 = 0;
   localparam int KIND_CGT6 = 1;
   localparam int KIND_CONV = 2;

   typedef enum logic {MODE_LONG = 1'b0, MODE_SHORT = 1'b1} blk_mode_e;

   // j-th odd number below 36 that is not a multiple of 3: 1,5,7,11,13,...
   function automatic int unit_of(input int j);
      return 6 * (j / 2) + (((j % 2) != 0) ? 5 : 1);
   endfunction

   function automatic bit lane_is_unit(input int k);
      return ((2 * k + 1) % 3) != 0;
   endfunction

   // cos(pi*num/den), evaluated by series after range reduction
   function automatic real cos_pi_ratio(input int num, input int den);
      int  m;
      real th, term, acc;
      m = num % (2 * den);
      if (m < 0) m = m + 2 * den;
      th = 3.14159265358979323846 * real'(m) / real'(den);
      if (th > 3.14159265358979323846) th = th - 6.28318530717958647692;
      term = 1.0;
      acc  = 1.0;
      for (int n = 1; n <= 22; n++) begin
         term = -term * th * th / real'((2 * n - 1) * (2 * n));
         acc  = acc + term;
      end
      return acc;
   endfunction

   // quantised coefficient of one cell of a constant matrix
   function automatic int coef_q(input int kind, input int r, input int c, input int fb);
      real v, scale;
      scale = 1.0;
      for (int n = 0; n < fb; n++) scale = scale * 2.0;
      if (kind == KIND_DCT6)
         v = cos_pi_ratio((2 * r + 1) * (2 * c + 1), 24);
      else if (kind == KIND_CGT6)
         v = cos_pi_ratio((2 * c + 1) * unit_of(r), 24);
      else
         v = cos_pi_ratio(unit_of(c) * unit_of(r), 72);
      return int'(v * scale);
   endfunction

endpackage

// File: rtl/dct18_fold.sv
module dct18_fold
   import dct18_pkg::*;
#(
   parameter int DW = 16
)(
   input  logic                 mode_short,
   input  logic signed [DW-1:0] xv    [NPT],
   output logic signed [DW+1:0] yf    [NSUB],
   output logic signed [DW-1:0] gsub  [NSUB],
   output logic signed [DW-1:0] gconv [NUNIT]
);
   localparam int YW = DW + 2;

   if (DW < 4) begin : g_bad_dw
      $error("dct18_fold: DW must be at least 4");
   end

   // folded operand for the 6-point section; raw lanes in short mode
   for (genvar i = 0; i < NSUB; i++) begin : g_fold
      logic signed [YW-1:0] folded;
      assign folded  = YW'(xv[i]) - YW'(xv[11-i]) - YW'(xv[12+i]);
      assign yf[i]   = mode_short ? YW'(xv[i]) : folded;
      // samples with 2i+1 a multiple of 3: lanes 1,4,7,...
      assign gsub[i] = mode_short ? '0 : xv[3*i+1];
   end

   // samples whose odd index is coprime to 144, in unit order
   for (genvar j = 0; j < NUNIT; j++) begin : g_unit
      localparam int SRC = (unit_of(j) - 1) / 2;
      assign gconv[j] = mode_short ? '0 : xv[SRC];
   end

endmodule

// File: rtl/dct18_cmat.sv
module dct18_cmat
   import dct18_pkg::*;
#(
   parameter  int ROWS = 6,
   parameter  int COLS = 6,
   parameter  int IW   = 18,
   parameter  int CW   = 16,
   parameter  int FB   = 14,
   parameter  int KIND = 0,
   localparam int PW   = IW + CW,
   localparam int SW   = IW + CW + $clog2(COLS) + 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic signed [IW-1:0] din  [COLS],
   output logic signed [SW-1:0] rsum [ROWS]
);

   if (CW < FB + 2) begin : g_bad_cw
      $error("dct18_cmat: CW must hold a coefficient of magnitude 1.0");
   end
   if (KIND < KIND_DCT6 || KIND > KIND_CONV) begin : g_bad_kind
      $error("dct18_cmat: unknown matrix kind");
   end

   logic signed [PW-1:0] prod_w [ROWS*COLS];

   // single multiplier stage, registered
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam logic signed [CW-1:0] KQ = CW'(coef_q(KIND, r, c, FB));
         logic signed [PW-1:0] p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               p_q <= '0;
            else if (load)
               p_q <= PW'(din[c]) * PW'(KQ);
         end
         assign prod_w[r*COLS+c] = p_q;
      end

      always_comb begin
         logic signed [SW-1:0] acc;
         acc = '0;
         for (int c = 0; c < COLS; c++)
            acc = acc + SW'(prod_w[r*COLS+c]);
         rsum[r] = acc;
      end
   end

   // R6
   // products move only on a loaded block
   prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(rsum[0]));

endmodule

// File: rtl/dct18_core.sv
module dct18_core
   import dct18_pkg::*;
#(
   parameter  int DW         = 16,
   parameter  int FB         = 14,
   parameter  bit ROUND_NEAR = 1'b0,
   localparam int CW         = FB + 2,
   localparam int OW         = DW + 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_mode,
   input  logic [NPT*DW-1:0] x_in,
   output logic              out_valid,
   output logic [NPT*OW-1:0] x_out
);
   localparam int YW  = DW + 2;
   localparam int SW6 = YW + CW + $clog2(NSUB) + 1;
   localparam int SWG = DW + CW + $clog2(NSUB) + 1;
   localparam int SWC = DW + CW + $clog2(NUNIT) + 1;
   localparam int LW  = DW + CW + 6;

   if (FB < 2 || FB > 24) begin : g_bad_fb
      $error("dct18_core: FB out of range");
   end
   if (LW <= SW6 - 1 || LW <= SWC) begin : g_bad_lw
      $error("dct18_core: post-add width too small");
   end

   // ---------------- input unpack and operand preparation ----------------
   logic signed [DW-1:0] xv [NPT];
   for (genvar i = 0; i < NPT; i++) begin : g_unpack
      assign xv[i] = x_in[i*DW +: DW];
   end

   logic mode_short;
   assign mode_short = (blk_mode_e'(in_mode) == MODE_SHORT);

   logic signed [YW-1:0] yf    [NSUB];
   logic signed [DW-1:0] gsub  [NSUB];
   logic signed [DW-1:0] gconv [NUNIT];

   dct18_fold #(.DW(DW)) u_fold (
      .mode_short (mode_short),
      .xv         (xv),
      .yf         (yf),
      .gsub       (gsub),
      .gconv      (gconv)
   );

   // ---------------- multiplier stage (registered) ----------------
   logic signed [SW6-1:0] d6_s   [NSUB];
   logic signed [SWG-1:0] cgt_s  [NHALF];
   logic signed [SWC-1:0] conv_s [NUNIT];

   dct18_cmat #(.ROWS(NSUB), .COLS(NSUB), .IW(YW), .CW(CW), .FB(FB), .KIND(KIND_DCT6)) u_dct6 (
      .clk (clk), .rst_n (rst_n), .load (in_valid), .din (yf), .rsum (d6_s)
   );

   dct18_cmat #(.ROWS(NHALF), .COLS(NSUB), .IW(DW), .CW(CW), .FB(FB), .KIND(KIND_CGT6)) u_cgt6 (
      .clk (clk), .rst_n (rst_n), .load (in_valid), .din (gsub), .rsum (cgt_s)
   );

   dct18_cmat #(.ROWS(NUNIT), .COLS(NUNIT), .IW(DW), .CW(CW), .FB(FB), .KIND(KIND_CONV)) u_conv (
      .clk (clk), .rst_n (rst_n), .load (in_valid), .din (gconv), .rsum (conv_s)
   );

   logic v1_q, mode1_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q    <= 1'b0;
         mode1_q <= 1'b0;
      end else begin
         v1_q <= in_valid;
         if (in_valid) mode1_q <= mode_short;
      end
   end

   // ---------------- post-addition ----------------
   logic signed [LW-1:0] lane_full [NPT];

   for (genvar r = 0; r < NSUB; r++) begin : g_d6lane
      assign lane_full[3*r+1] = LW'(d6_s[r]);
   end

   for (genvar j = 0; j < NUNIT; j++) begin : g_ulane
      localparam int B  = unit_of(j);
      localparam int KO = (B - 1) / 2;
      localparam int D  = (B < 12) ? B : ((B < 24) ? 24 - B : B - 24);
      localparam int SI = (D == 1) ? 0 : ((D == 5) ? 1 : ((D == 7) ? 2 : 3));
      if (B < 12) begin : g_pos
         assign lane_full[KO] = LW'(conv_s[j]) + LW'(cgt_s[SI]);
      end else begin : g_neg
         assign lane_full[KO] = LW'(conv_s[j]) - LW'(cgt_s[SI]);
      end
   end

   // rounding variant chosen at elaboration
   logic signed [LW-1:0] bias;
   if (ROUND_NEAR) begin : g_rnd
      assign bias = LW'(1) <<< (FB - 1);
   end else begin : g_flr
      assign bias = '0;
   end

   logic signed [OW-1:0] lane_out [NPT];
   always_comb begin
      for (int k = 0; k < NPT; k++) begin
         if (mode1_q && k < NSUB)
            lane_out[k] = OW'((LW'(d6_s[k]) + bias) >>> FB);
         else if (mode1_q && !lane_is_unit(k))
            lane_out[k] = '0;
         else
            lane_out[k] = OW'((lane_full[k] + bias) >>> FB);
      end
   end

   // ---------------- output register ----------------
   logic signed [OW-1:0] out_q [NPT];
   logic                 ov_q, mode2_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q    <= 1'b0;
         mode2_q <= 1'b0;
         for (int k = 0; k < NPT; k++) out_q[k] <= '0;
      end else begin
         ov_q <= v1_q;
         if (v1_q) begin
            mode2_q <= mode1_q;
            for (int k = 0; k < NPT; k++) out_q[k] <= lane_out[k];
         end
      end
   end

   assign out_valid = ov_q;
   for (genvar k = 0; k < NPT; k++) begin : g_pack
      assign x_out[k*OW +: OW] = out_q[k];
   end

   // R5
   lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 2));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(x_out));

   // R4
   short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode2_q) |-> (x_out[NPT*OW-1:NSUB*OW] == '0));

endmodule

// File: tb/dct18_core_tb.sv
module dct18_core_tb;
   import dct18_pkg::*;

   localparam int DW = 16;
   localparam int FB = 14;
   localparam int OW = DW + 5;
   localparam real PI = 3.14159265358979323846;

   typedef struct packed {
      logic       mode;
      logic [2:0] kind;
      logic [15:0] amp;
      logic [7:0] seed;
   } vec_t;

   // mode, pattern kind, amplitude, seed
   localparam vec_t TBL [12] = '{
      '{1'b0, 3'd0, 16'd0,     8'd0},
      '{1'b0, 3'd1, 16'd1000,  8'd0},
      '{1'b0, 3'd1, 16'd1000,  8'd13},
      '{1'b0, 3'd2, 16'd1500,  8'd0},
      '{1'b0, 3'd3, 16'd1200,  8'd0},
      '{1'b0, 3'd4, 16'd2000,  8'd0},
      '{1'b0, 3'd5, 16'd3000,  8'd1},
      '{1'b0, 3'd5, 16'd30000, 8'd7},
      '{1'b1, 3'd1, 16'd1000,  8'd2},
      '{1'b1, 3'd5, 16'd3000,  8'd3},
      '{1'b1, 3'd3, 16'd2500,  8'd0},
      '{1'b1, 3'd5, 16'd32000, 8'd9}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid;
   logic              in_mode;
   logic [NPT*DW-1:0] x_in;
   logic              out_valid;
   logic [NPT*OW-1:0] x_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   dct18_core #(.DW(DW), .FB(FB)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_mode   (in_mode),
      .x_in      (x_in),
      .out_valid (out_valid),
      .x_out     (x_out)
   );

   function automatic int gen(input int kind, input int amp, input int seed, input int i);
      longint h;
      case (kind)
         0: return 0;
         1: return (i == seed % NPT) ? amp : 0;
         2: return amp;
         3: return ((i % 2) == 0) ? amp : -amp;
         4: return (i * amp) / 17 - amp / 2;
         default: begin
            h = longint'(seed + 1) * 7919 + longint'(i) * 104729 + longint'(i * i) * 613;
            return int'(h % longint'(2 * amp + 1)) - amp;
         end
      endcase
   endfunction

   function automatic real ref_val(input int v [NPT], input bit shrt, input int k);
      real s;
      s = 0.0;
      if (!shrt) begin
         for (int i = 0; i < NPT; i++)
            s = s + real'(v[i]) * $cos(PI * real'((2*i+1) * (2*k+1)) / 72.0);
      end else if (k < NSUB) begin
         for (int i = 0; i < NSUB; i++)
            s = s + real'(v[i]) * $cos(PI * real'((2*i+1) * (2*k+1)) / 24.0);
      end
      return s;
   endfunction

   function automatic int lane(input int k);
      logic signed [OW-1:0] w;
      w = x_out[k*OW +: OW];
      return int'(w);
   endfunction

   task automatic tick(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // grp 0: long lanes with 2k+1 multiple of 3; 1: long coprime lanes;
   // 2: short lanes 0..5; 3: short lanes 6..17 (exact zero)
   task automatic check_lanes(input int v [NPT], input int grp, input string req);
      real sumabs, tol, e, d;
      int  a;
      bit  bad;
      bit  shrt;
      bit  sel;
      shrt   = (grp >= 2);
      sumabs = 0.0;
      for (int i = 0; i < (shrt ? NSUB : NPT); i++)
         sumabs = sumabs + ((v[i] < 0) ? -real'(v[i]) : real'(v[i]));
      tol = (grp == 3) ? 0.0 : 2.0 + sumabs / real'(1 << (FB + 1));
      bad = 1'b0;
      n_chk++;
      for (int k = 0; k < NPT; k++) begin
         case (grp)
            0: sel = !lane_is_unit(k);
            1: sel = lane_is_unit(k);
            2: sel = (k < NSUB);
            default: sel = (k >= NSUB);
         endcase
         if (sel && !bad) begin
            e = ref_val(v, shrt, k);
            a = lane(k);
            d = real'(a) - e;
            if (d < 0.0) d = -d;
            if (d > tol) begin
               bad = 1'b1;
               n_bad++;
               $display("FAIL %s lane %0d: actual %0d expected %0.3f (tol %0.2f)", req, k, a, e, tol);
            end
         end
      end
   endtask

   task automatic drive(input int v [NPT], input bit shrt);
      for (int i = 0; i < NPT; i++) x_in[i*DW +: DW] = v[i][DW-1:0];
      in_mode  = shrt;
      in_valid = 1'b1;
   endtask

   task automatic check_block(input int v [NPT], input bit shrt, input string tagl, input string tagh);
      if (!shrt) begin
         check_lanes(v, 0, tagl);
         check_lanes(v, 1, tagh);
      end else begin
         check_lanes(v, 2, tagl);
         check_lanes(v, 3, tagh);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         finish_run();
      end
   end

   initial begin
      int va [NPT];
      int vb [NPT];
      int vc [NPT];
      logic [NPT*OW-1:0] held;

      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_mode  = 1'b0;
      x_in     = '0;
      repeat (3) @(negedge clk);
      // R7: reset state
      tick(out_valid == 1'b0, "R7", "out_valid in reset", longint'(out_valid), 0);
      tick(x_out == '0, "R7", "x_out in reset", longint'(x_out != '0), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R1, R2 (long), R3, R4 (short), R5 timing
      foreach (TBL[t]) begin
         for (int i = 0; i < NPT; i++)
            va[i] = gen(int'(TBL[t].kind), int'(TBL[t].amp), int'(TBL[t].seed), i);
         drive(va, TBL[t].mode);
         @(negedge clk);
         in_valid = 1'b0;
         tick(out_valid == 1'b0, "R5", "out_valid one edge after", longint'(out_valid), 0);
         @(negedge clk);
         tick(out_valid == 1'b1, "R5", "out_valid two edges after", longint'(out_valid), 1);
         if (TBL[t].mode) check_block(va, 1'b1, "R3", "R4");
         else             check_block(va, 1'b0, "R1", "R2");
         @(negedge clk);
         tick(out_valid == 1'b0, "R5", "single-cycle out_valid", longint'(out_valid), 0);
      end

      // R8: back-to-back blocks with alternating mode
      for (int i = 0; i < NPT; i++) begin
         va[i] = gen(5, 4000, 21, i);
         vb[i] = gen(5, 4000, 33, i);
         vc[i] = gen(1, 2500, 11, i);
      end
      drive(va, 1'b0);
      @(negedge clk);
      drive(vb, 1'b1);
      @(negedge clk);
      drive(vc, 1'b0);
      tick(out_valid == 1'b1, "R8", "first of burst valid", longint'(out_valid), 1);
      check_block(va, 1'b0, "R8", "R8");
      @(negedge clk);
      in_valid = 1'b0;
      check_block(vb, 1'b1, "R8", "R8");
      @(negedge clk);
      tick(out_valid == 1'b1, "R8", "last of burst valid", longint'(out_valid), 1);
      check_block(vc, 1'b0, "R8", "R8");

      // R6: outputs hold while inputs and mode wander without valid
      held = x_out;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         x_in    = {NPT{16'h5A5A}} ^ (NPT*DW)'(c * 977);
         in_mode = c[0];
         tick(x_out == held && out_valid == 1'b0, "R6", "hold without valid",
              longint'(x_out != held), 0);
      end

      // R9: full-scale stimulus
      for (int i = 0; i < NPT; i++) va[i] = -32768;
      for (int i = 0; i < NPT; i++) vb[i] = ((i % 3) == 0) ? 32767 : -32768;
      for (int i = 0; i < NPT; i++) vc[i] = (i < 12) ? 32767 : -32768;
      drive(va, 1'b0);
      @(negedge clk);
      drive(vb, 1'b0);
      @(negedge clk);
      drive(vc, 1'b1);
      check_block(va, 1'b0, "R9", "R9");
      @(negedge clk);
      in_valid = 1'b0;
      check_block(vb, 1'b0, "R9", "R9");
      @(negedge clk);
      check_block(vc, 1'b1, "R9", "R9");

      // R7: reset in the middle of a block discards it
      for (int i = 0; i < NPT; i++) va[i] = gen(5, 5000, 40, i);
      drive(va, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      @(negedge clk);
      tick(out_valid == 1'b0, "R7", "out_valid after mid reset", longint'(out_valid), 0);
      tick(x_out == '0, "R7", "x_out after mid reset", longint'(x_out != '0), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      tick(out_valid == 1'b0, "R7", "discarded block stays gone", longint'(out_valid), 0);

      done = 1'b1;
      finish_run();
   end

endmodule